// File: doc/BRIEF.md
# Word rotate-and-mask unit

This combinational unit serves the integer pipe of a 64-bit core. It takes the low 32-bit word of a source operand and rotates it left. The rotate amount comes either from a 5-bit immediate or from the low five bits of a second register. The rotated word is copied into both halves of a 64-bit value. That value is then filtered through a mask defined by a begin position and an end position.

In AND mode, bits outside the mask are cleared. In insert mode, bits outside the mask are taken from the previous destination value. This lets software place a bit field anywhere in a word.

When the record input is set, the unit also produces a 4-bit condition field. The field compares the 64-bit result, taken as signed, against zero, and copies in a summary-overflow flag. The unit has no state, so the result follows the inputs in the same cycle.

Top module: `rotmask_unit`

## Requirements
- R1: With `amt_sel_reg_i`=1 the rotate amount is `rb_i[4:0]`, so the upper 59 bits of `rb_i` and all of `sh_i` have no effect. With `amt_sel_reg_i`=0 the amount is `sh_i`.
- R2: Bit positions use big-endian numbering: position 0 is the MSB. Word position q maps to result bit index 31-q, and is position 32+q of the 64-bit value. With `mb_i` <= `me_i`, the word mask has ones at positions `mb_i` through `me_i` inclusive and zeros elsewhere.
- R3: With `mb_i` > `me_i`, the mask wraps around the end of the word. The word mask has ones from `mb_i` to position 31 and from position 0 to `me_i`, and every bit of the upper half (indices 63..32) of the mask is one.
- R4: In AND mode (`insert_i`=0) the result is the 64-bit rotated value ANDed with the mask. Without wrap, the upper half of the result is zero.
- R5: The rotated word appears in both halves of the 64-bit value, so a wrapping mask puts the rotated word into result bits 63..32.
- R6: In insert mode (`insert_i`=1) each result bit equals the rotated bit where the mask is one, and the `dst_old_i` bit where it is zero.
- R7: `src_i[63:32]` has no effect on any output.
- R8: With `record_i`=1, `cr_we_o`=1 and `cr_o` = {LT, GT, EQ, SO} in bits 3..0. Exactly one of LT, GT and EQ is set, from a signed compare of `result_o` with zero. SO equals `so_i`.
- R9: With `record_i`=0, `cr_we_o`=0 and `cr_o`=0.
- R10: `mb_i`=0 with `me_i`=31 yields the plain rotated word in the lower half. `mb_i`=`me_i` selects a single bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Source operand; only bits 31..0 are rotated |
| dst_old_i | input | 64 | Previous destination value used by insert mode |
| rb_i | input | 64 | Second register; bits 4..0 give the rotate amount |
| sh_i | input | 5 | Immediate rotate amount |
| amt_sel_reg_i | input | 1 | 1: amount from `rb_i`, 0: from `sh_i` |
| mb_i | input | 5 | Mask begin position within the word |
| me_i | input | 5 | Mask end position within the word |
| insert_i | input | 1 | 1: merge under mask, 0: AND with mask |
| record_i | input | 1 | Request a condition field |
| so_i | input | 1 | Summary-overflow flag copied into the condition field |
| result_o | output | 64 | Rotated and masked result |
| cr_we_o | output | 1 | Condition field is valid |
| cr_o | output | 4 | {LT, GT, EQ, SO} |

## Verification
The riskiest overlap is a wrapping mask used together with insert mode. In that case the upper half of the result must come entirely from the replicated rotated word, while only the unmasked middle bits of the lower half keep the old destination value. The same vector also sets the record bit, so the sign of that mixed result decides LT. One table vector drives this combination with distinct patterns in the source and old-destination operands, so each half of the result can be told apart. A full sweep over every begin/end pair then compares both halves of the result against a position-by-position mask model.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  // source of the rotate amount
  typedef enum logic {
    AMT_IMM = 1'b0,
    AMT_REG = 1'b1
  } amt_src_e;

  // condition field layout, MSB first
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/rotmask_rotl.sv
// Logarithmic left rotator for one word.
module rotmask_rotl #(
  parameter int WORD  = 32,
  localparam int AMT_W = $clog2(WORD)
) (
  input  logic [WORD-1:0]  word_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [WORD-1:0]  rot_o
);
  logic [WORD-1:0] stage [AMT_W+1];

  assign stage[0] = word_i;

  generate
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      assign stage[k+1] = amt_i[k]
        ? {stage[k][WORD-1-STEP:0], stage[k][WORD-1:WORD-STEP]}
        : stage[k];
    end
  endgenerate

  assign rot_o = stage[AMT_W];
endmodule

// File: rtl/rotmask_maskgen.sv
// Begin/end mask with wrap, big-endian positions.
module rotmask_maskgen #(
  parameter int XLEN  = 64,
  localparam int WORD  = XLEN / 2,
  localparam int AMT_W = $clog2(WORD)
) (
  input  logic [AMT_W-1:0] mb_i,
  input  logic [AMT_W-1:0] me_i,
  output logic [XLEN-1:0]  mask_o
);
  logic            wrap;
  logic [WORD-1:0] word_mask;

  assign wrap = mb_i > me_i;

  generate
    for (genvar q = 0; q < WORD; q++) begin : g_pos
      localparam logic [AMT_W-1:0] POS = AMT_W'(q);
      logic at_or_after_b;
      logic at_or_before_e;
      assign at_or_after_b  = POS >= mb_i;
      assign at_or_before_e = POS <= me_i;
      assign word_mask[WORD-1-q] = wrap ? (at_or_after_b | at_or_before_e)
                                        : (at_or_after_b & at_or_before_e);
    end
  endgenerate

  assign mask_o = {{WORD{wrap}}, word_mask};
endmodule

// File: rtl/rotmask_cond.sv
// Signed compare against zero plus summary overflow.
module rotmask_cond #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] value_i,
  input  logic            so_i,
  input  logic            record_i,
  output logic            cr_we_o,
  output logic [3:0]      cr_o
);
  import rotmask_pkg::*;

  cond_t fld;
  logic  neg;
  logic  zero;

  always_comb begin
    neg  = value_i[XLEN-1];
    zero = (value_i == '0);
    fld  = '0;
    if (record_i) begin
      fld.lt = neg;
      fld.gt = !neg && !zero;
      fld.eq = zero;
      fld.so = so_i;
    end
  end

  assign cr_we_o = record_i;
  assign cr_o    = fld;
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int XLEN  = 64,
  localparam int WORD  = XLEN / 2,
  localparam int AMT_W = $clog2(WORD)
) (
  input  logic [XLEN-1:0]  src_i,
  input  logic [XLEN-1:0]  dst_old_i,
  input  logic [XLEN-1:0]  rb_i,
  input  logic [AMT_W-1:0] sh_i,
  input  logic             amt_sel_reg_i,
  input  logic [AMT_W-1:0] mb_i,
  input  logic [AMT_W-1:0] me_i,
  input  logic             insert_i,
  input  logic             record_i,
  input  logic             so_i,
  output logic [XLEN-1:0]  result_o,
  output logic             cr_we_o,
  output logic [3:0]       cr_o
);
  import rotmask_pkg::*;

  logic [AMT_W-1:0] amount;
  logic [WORD-1:0]  rot_word;
  logic [XLEN-1:0]  rot_dbl;
  logic [XLEN-1:0]  mask;
  logic [XLEN-1:0]  merged;

  always_comb begin
    unique case (amt_src_e'(amt_sel_reg_i))
      AMT_REG: amount = rb_i[AMT_W-1:0];
      default: amount = sh_i;
    endcase
  end

  rotmask_rotl #(.WORD(WORD)) u_rotl (
    .word_i (src_i[WORD-1:0]),
    .amt_i  (amount),
    .rot_o  (rot_word)
  );

  assign rot_dbl = {rot_word, rot_word};

  rotmask_maskgen #(.XLEN(XLEN)) u_mask (
    .mb_i   (mb_i),
    .me_i   (me_i),
    .mask_o (mask)
  );

  always_comb begin
    if (insert_i) merged = (rot_dbl & mask) | (dst_old_i & ~mask);
    else          merged = rot_dbl & mask;
  end

  assign result_o = merged;

  rotmask_cond #(.XLEN(XLEN)) u_cond (
    .value_i  (merged),
    .so_i     (so_i),
    .record_i (record_i),
    .cr_we_o  (cr_we_o),
    .cr_o     (cr_o)
  );
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
  parameter int XLEN  = 64,
  localparam int WORD  = XLEN / 2,
  localparam int AMT_W = $clog2(WORD)
) (
  input logic [XLEN-1:0]  dst_old_i,
  input logic [AMT_W-1:0] mb_i,
  input logic [AMT_W-1:0] me_i,
  input logic             insert_i,
  input logic             record_i,
  input logic             so_i,
  input logic [XLEN-1:0]  mask,
  input logic [XLEN-1:0]  result_o,
  input logic             cr_we_o,
  input logic [3:0]       cr_o
);
  always_comb begin
    // R2
    mask_edges_chk: assert (mask[WORD-1-int'(mb_i)] && mask[WORD-1-int'(me_i)]);
    // R3
    mask_wrap_chk: assert ((mb_i > me_i) ? (&mask[XLEN-1:WORD]) : (mask[XLEN-1:WORD] == '0));
    // R4
    and_clear_chk: assert (insert_i || ((result_o & ~mask) == '0));
    // R6
    insert_keep_chk: assert (!insert_i || (((result_o ^ dst_old_i) & ~mask) == '0));
    // R8
    cr_onehot_chk: assert (!record_i || (cr_we_o && $onehot(cr_o[3:1]) && cr_o[0] == so_i));
    // R9
    cr_quiet_chk: assert (record_i || (!cr_we_o && cr_o == 4'b0000));
  end
endmodule

bind rotmask_unit rotmask_unit_chk #(.XLEN(XLEN)) u_chk (
  .dst_old_i (dst_old_i),
  .mb_i      (mb_i),
  .me_i      (me_i),
  .insert_i  (insert_i),
  .record_i  (record_i),
  .so_i      (so_i),
  .mask      (mask),
  .result_o  (result_o),
  .cr_we_o   (cr_we_o),
  .cr_o      (cr_o)
);

// File: tb/tb_rotmask_unit.sv
module tb_rotmask_unit;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [63:0] src, old, rb, res;
  logic [4:0]  sh, mb, me;
  logic        sel, ins, rec, so, crwe;
  logic [3:0]  cr;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  rotmask_unit #(.XLEN(XLEN)) dut (
    .src_i(src), .dst_old_i(old), .rb_i(rb), .sh_i(sh), .amt_sel_reg_i(sel),
    .mb_i(mb), .me_i(me), .insert_i(ins), .record_i(rec), .so_i(so),
    .result_o(res), .cr_we_o(crwe), .cr_o(cr)
  );

  typedef struct packed {
    logic [63:0] src;
    logic [63:0] old;
    logic [63:0] rb;
    logic [4:0]  sh;
    logic        sel;
    logic [4:0]  mb;
    logic [4:0]  me;
    logic        ins;
    logic        rec;
    logic        so;
    logic [63:0] exp_res;
    logic [3:0]  exp_cr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    // R4 R10 R8: full mask, immediate 4, positive
    '{64'h0000_0000_1234_5678, 64'h0, 64'h0, 5'd4, 1'b0, 5'd0, 5'd31, 1'b0, 1'b1, 1'b0,
      64'h0000_0000_2345_6781, 4'b0100},
    // R1: amount 8 from register, immediate ignored
    '{64'h0000_0000_1234_5678, 64'h0, 64'hFFFF_FFFF_FFFF_FFE8, 5'd3, 1'b1, 5'd0, 5'd31, 1'b0, 1'b0, 1'b0,
      64'h0000_0000_3456_7812, 4'b0000},
    // R2: positions 8..15
    '{64'h0000_0000_AABB_CCDD, 64'h0, 64'h0, 5'd0, 1'b0, 5'd8, 5'd15, 1'b0, 1'b1, 1'b1,
      64'h0000_0000_00BB_0000, 4'b0101},
    // R3 R5: wrap 28..3, upper half gets the word
    '{64'h0000_0000_89AB_CDEF, 64'h0, 64'h0, 5'd0, 1'b0, 5'd28, 5'd3, 1'b0, 1'b1, 1'b0,
      64'h89AB_CDEF_8000_000F, 4'b1000},
    // R6: insert at 16..23
    '{64'h0000_0000_1122_3344, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 5'd8, 1'b0, 5'd16, 5'd23, 1'b1, 1'b1, 1'b0,
      64'hDEAD_BEEF_CAFE_440D, 4'b1000},
    // R7 R8: upper source ignored, result positive as 64-bit
    '{64'hFFFF_FFFF_0000_0001, 64'h0, 64'h0, 5'd31, 1'b0, 5'd0, 5'd31, 1'b0, 1'b1, 1'b0,
      64'h0000_0000_8000_0000, 4'b0100},
    // R8: zero result
    '{64'h0000_0000_0000_FFFF, 64'h0, 64'h0, 5'd0, 1'b0, 5'd0, 5'd15, 1'b0, 1'b1, 1'b1,
      64'h0, 4'b0011},
    // R10: single bit
    '{64'h0000_0000_0000_0003, 64'h0, 64'h0, 5'd0, 1'b0, 5'd31, 5'd31, 1'b0, 1'b0, 1'b0,
      64'h0000_0000_0000_0001, 4'b0000},
    // R1: register amount zero, high bits of rb set
    '{64'h0000_0000_1234_5678, 64'h0, 64'h0000_0000_0000_00E0, 5'd17, 1'b1, 5'd0, 5'd31, 1'b0, 1'b0, 1'b0,
      64'h0000_0000_1234_5678, 4'b0000},
    // R3 R6: wrap together with insert
    '{64'h0000_0000_C000_0003, 64'h0123_4567_89AB_CDEF, 64'h0, 5'd0, 1'b0, 5'd30, 5'd1, 1'b1, 1'b1, 1'b1,
      64'hC000_0003_C9AB_CDEF, 4'b1001}
  };

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check4(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_rotl(input logic [31:0] w, input int n);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) o[(i + n) % 32] = w[i];
    return o;
  endfunction

  function automatic logic [31:0] ref_mask(input int b, input int e);
    logic [31:0] o;
    for (int p = 0; p < 32; p++) begin
      logic in;
      in = (b <= e) ? (p >= b && p <= e) : !(p > e && p < b);
      o[31 - p] = in;
    end
    return o;
  endfunction

  task automatic drive(input vec_t v);
    @(negedge clk);
    src = v.src; old = v.old; rb = v.rb; sh = v.sh; sel = v.sel;
    mb = v.mb; me = v.me; ins = v.ins; rec = v.rec; so = v.so;
    #1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    src = '0; old = '0; rb = '0; sh = '0; sel = 1'b0;
    mb = '0; me = '0; ins = 1'b0; rec = 1'b0; so = 1'b0;
    @(negedge clk);
    #1;
    // R9 idle state: all-zero inputs
    check64("R9 idle result", res, 64'h0);
    check4("R9 idle cr", {crwe, cr}, 5'b00000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check64($sformatf("R4/R6 vec%0d result", i), res, VEC[i].exp_res);
      check4($sformatf("R8/R9 vec%0d cr", i), {crwe, cr}, {VEC[i].rec, VEC[i].exp_cr});
    end

    // R2 R3 R5: every begin/end pair, all-ones word, no rotation
    for (int b = 0; b < 32; b++) begin
      for (int e = 0; e < 32; e++) begin
        logic [31:0] m;
        m = ref_mask(b, e);
        @(negedge clk);
        src = 64'h0000_0000_FFFF_FFFF; sel = 1'b0; sh = '0; ins = 1'b0; rec = 1'b0;
        mb = 5'(b); me = 5'(e);
        #1;
        check64("R2/R3 mask sweep", res, {(b > e) ? 32'hFFFF_FFFF : 32'h0, m});
      end
    end

    // R1 R10: every amount in both sources, full mask
    for (int n = 0; n < 32; n++) begin
      @(negedge clk);
      src = 64'h5A5A_5A5A_8421_F00D; mb = 5'd0; me = 5'd31; ins = 1'b0; rec = 1'b0;
      sel = 1'b0; sh = 5'(n); rb = 64'hFFFF_FFFF_FFFF_FFFF;
      #1;
      check64("R1 immediate amount", res, {32'h0, ref_rotl(32'h8421_F00D, n)});
      @(negedge clk);
      sel = 1'b1; sh = 5'(31 - n); rb = {59'h5_5555_5555_5555_55, 5'(n)};
      #1;
      check64("R1 register amount", res, {32'h0, ref_rotl(32'h8421_F00D, n)});
    end

    // R6: insert with empty-looking narrow field keeps old upper half
    @(negedge clk);
    src = 64'h0; old = 64'hFFFF_FFFF_FFFF_FFFF; sel = 1'b0; sh = '0;
    mb = 5'd0; me = 5'd0; ins = 1'b1; rec = 1'b1; so = 1'b0;
    #1;
    check64("R6 insert zero bit", res, 64'hFFFF_FFFF_7FFF_FFFF);
    check4("R8 insert negative", {crwe, cr}, 5'b11000);

    finish_run();
  end
endmodule